// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs read and write transactions on the two-wire serial management bus that reaches 16-bit registers inside Ethernet PHY devices. The caller presents an operation (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word, and pulses `start_i` while the block is idle. The block makes the management clock by dividing the system clock, shifts the frame out on `mdo_o`, controls the pad direction with `mdoe_o`, and samples `mdi_i` during the read phase. When the frame is over it gives a one-cycle `done_o` pulse, with the read word and a no-response flag valid in that cycle.

Every frame has exactly 64 MDC cells. Each cell is one low half-period followed by one high half-period, and each half-period lasts `HALF_CYCLES` system clocks. The frame is 32 preamble cells with the data line held at 1, then 14 header cells (start code, opcode, PHY address, register address), then 18 tail cells. On a write the tail holds the turnaround pattern and the data word. On a read the line is released for the whole tail: the first tail cell is a turnaround pulse, MDI is sampled as a response flag before the second tail cell's rising edge, and the last 16 cells each capture one data bit.

The controller has five states. IDLE leaves on an accepted start (IDLE→PREAMBLE). PREAMBLE moves to HEADER after its 32nd cell. HEADER moves to TURN after its 14th cell. TURN moves to DATA after its 2nd cell. DATA returns to IDLE after its 16th cell and raises done in the same step.

Top module: `mdio_master`

## Requirements
- R1: Out of reset, and while idle with no done pulse, MDC is low, the direction output is 1 (host drives), busy and done are 0, and the data output is 1.
- R2: Each frame begins with 32 MDC rising edges during which the data output is 1 and the direction output is 1.
- R3: Rising edges 33 to 46 carry, MSB first, start code 01, opcode (read 10, write 01), PHY address[4:0] and register address[4:0].
- R4: On a write, rising edges 47 to 64 carry turnaround pattern 10 and then write data[15:0] MSB first. The direction stays 1 for all 64 edges, and the frame has exactly 64 rising edges.
- R5: On a read, the direction output is 0 at rising edges 47 to 64, and the frame has exactly 64 rising edges.
- R6: On a read, MDI is sampled just before rising edge 48. A 1 sets the error flag and forces the returned data to 0. Writes report error 0.
- R7: On a read without error, the returned word holds the MDI values sampled just before rising edges 49 to 64, MSB first. Writes return 0.
- R8: The data output changes only while MDC is low. The direction output changes only when MDC was already low in the previous cycle, so no MDC edge coincides with a direction switch.
- R9: Inside a frame, each MDC high phase lasts HALF_CYCLES system clocks, and consecutive rising edges are 2*HALF_CYCLES clocks apart.
- R10: A start pulse while busy is ignored. The running frame is unchanged, and no second frame follows.
- R11: Busy rises in the cycle after an accepted start. Done is a single-cycle pulse, and busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| write_i | input | 1 | 1 = write frame, 0 = read frame |
| phy_i | input | 5 | PHY address |
| reg_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result, valid with done |
| err_o | output | 1 | No PHY response, valid with done |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Serial data toward the PHY |
| mdoe_o | output | 1 | 1 = host drives the data line |
| mdi_i | input | 1 | Serial data from the PHY |

## Verification
The checker watches four things on every clock: the line-level rules (data and direction change only while MDC is low, and direction only after MDC has already been low for a cycle), the exact length of each MDC high phase, the idle levels, and the start/busy/done handshake including the zeroed result on error. What goes out on the wire can only be shown by the bench scenarios, which act as a PHY. They are: the bit content of preamble, header and write tail; the 64-edge frame length; the released line during a read; the timing of the response-flag sample against the data capture; and the start pulse that is ignored mid-frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mdio_state_e;

    localparam int PHY_W     = 5;
    localparam int REG_W     = 5;
    localparam int DATA_W    = 16;
    localparam int CODE_W    = 2;
    localparam int PRE_CELLS = 32;
    localparam int HDR_BITS  = CODE_W + CODE_W + PHY_W + REG_W;
    localparam int TA_BITS   = CODE_W;
    localparam int FRAME_W   = HDR_BITS + TA_BITS + DATA_W;

    localparam logic [CODE_W-1:0] START_CODE = 2'b01;
    localparam logic [CODE_W-1:0] OP_READ    = 2'b10;
    localparam logic [CODE_W-1:0] OP_WRITE   = 2'b01;
    localparam logic [CODE_W-1:0] TA_WRITE   = 2'b10;

endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
    parameter int HALF_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/mdio_capture.sv
module mdio_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            data_o <= '0;
        end else if (shift_i) begin
            data_o <= {data_o[W-2:0], bit_i};
        end
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [PHY_W-1:0]  phy_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic              mdc_o,
    output logic              mdo_o,
    output logic              mdoe_o,
    input  logic              mdi_i
);
    localparam int CNT_W = $clog2(PRE_CELLS);

    mdio_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              half_q, half_d;
    logic [FRAME_W-1:0] tx_q, tx_d;
    logic              wr_q, wr_d;
    logic              err_q, err_d;
    logic              done_q, done_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic              oe_q, oe_d;

    logic              tick;
    logic              accept;
    logic              sample_data;
    logic [DATA_W-1:0] rx;

    assign accept      = (state_q == ST_IDLE) && start_i;
    assign sample_data = tick && !half_q && (state_q == ST_DATA) && !wr_q;

    mdio_tick #(.HALF_CYCLES(HALF_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (state_q != ST_IDLE),
        .tick_o (tick)
    );

    mdio_capture #(.W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .shift_i (sample_data),
        .bit_i   (mdi_i),
        .data_o  (rx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            half_q  <= 1'b0;
            tx_q    <= '0;
            wr_q    <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
            oe_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            half_q  <= half_d;
            tx_q    <= tx_d;
            wr_q    <= wr_d;
            err_q   <= err_d;
            done_q  <= done_d;
            rdata_q <= rdata_d;
            oe_q    <= oe_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        half_d  = half_q;
        tx_d    = tx_q;
        wr_d    = wr_q;
        err_d   = err_q;
        done_d  = 1'b0;
        rdata_d = rdata_q;
        // direction follows the state one cycle late, so it moves while MDC is low
        oe_d    = !(!wr_q && (state_q == ST_TA || state_q == ST_DATA));

        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_PRE;
                    cnt_d   = '0;
                    half_d  = 1'b0;
                    tx_d    = {START_CODE, (write_i ? OP_WRITE : OP_READ),
                               phy_i, reg_i, TA_WRITE, wdata_i};
                    wr_d    = write_i;
                    err_d   = 1'b0;
                end
            end
            ST_PRE, ST_HDR, ST_TA, ST_DATA: begin
                if (tick && !half_q) begin
                    // end of low half: rising edge follows, sample here
                    half_d = 1'b1;
                    if (state_q == ST_TA && cnt_q == CNT_W'(TA_BITS - 1) && !wr_q) begin
                        err_d = mdi_i;
                    end
                end else if (tick) begin
                    // end of high half: falling edge, move to next cell
                    half_d = 1'b0;
                    cnt_d  = cnt_q + 1'b1;
                    if (state_q != ST_PRE) begin
                        tx_d = {tx_q[FRAME_W-2:0], 1'b0};
                    end
                    unique case (state_q)
                        ST_PRE: begin
                            if (cnt_q == CNT_W'(PRE_CELLS - 1)) begin
                                state_d = ST_HDR;
                                cnt_d   = '0;
                            end
                        end
                        ST_HDR: begin
                            if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
                                state_d = ST_TA;
                                cnt_d   = '0;
                            end
                        end
                        ST_TA: begin
                            if (cnt_q == CNT_W'(TA_BITS - 1)) begin
                                state_d = ST_DATA;
                                cnt_d   = '0;
                            end
                        end
                        ST_DATA: begin
                            if (cnt_q == CNT_W'(DATA_W - 1)) begin
                                state_d = ST_IDLE;
                                cnt_d   = '0;
                                done_d  = 1'b1;
                                rdata_d = (wr_q || err_q) ? '0 : rx;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o  = (state_q != ST_IDLE);
        done_o  = done_q;
        rdata_o = rdata_q;
        err_o   = err_q && done_q;
        mdc_o   = half_q;
        mdoe_o  = oe_q;
        mdo_o   = (state_q == ST_HDR || state_q == ST_TA || state_q == ST_DATA)
                  ? tx_q[FRAME_W-1] : 1'b1;
    end

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int HALF_CYCLES = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [15:0] rdata,
    input logic        mdc,
    input logic        mdo,
    input logic        mdoe
);
    logic [15:0] hcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else begin
            hcnt <= mdc ? hcnt + 16'd1 : 16'd0;
        end
    end

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> (!mdc && mdoe)); // R1
    AST_MDO_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdo) |-> !mdc); // R8
    AST_DIR_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdoe) |-> (!mdc && !$past(mdc))); // R8
    AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hcnt == 16'(HALF_CYCLES))); // R9
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (rdata == 16'd0)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R11
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R11

endmodule

bind mdio_master mdio_master_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .busy  (busy_o),
    .done  (done_o),
    .err   (err_o),
    .rdata (rdata_o),
    .mdc   (mdc_o),
    .mdo   (mdo_o),
    .mdoe  (mdoe_o)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
    localparam int HALF  = 4;
    localparam int CAPN  = 2048;
    localparam int NRAND = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        write = 1'b0;
    logic [4:0]  phy = '0;
    logic [4:0]  regad = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, err, mdc, mdo, mdoe;
    logic [15:0] rdata;
    logic        mdi = 1'b1;

    int checks = 0;
    int errors = 0;

    mdio_master #(.HALF_CYCLES(HALF)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .start_i(start), .write_i(write),
        .phy_i(phy), .reg_i(regad), .wdata_i(wdata),
        .busy_o(busy), .done_o(done), .rdata_o(rdata), .err_o(err),
        .mdc_o(mdc), .mdo_o(mdo), .mdoe_o(mdoe), .mdi_i(mdi)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // PHY model: records the line at each rising edge, drives MDI for the next cell
    int          edge_total = 0;
    int          base = 0;
    int          last_cyc = 0;
    int          per_bad = 0;
    logic        cap_mdo [CAPN];
    logic        cap_oe  [CAPN];
    logic        m_resp = 1'b0;
    logic        m_errbit = 1'b0;
    logic [15:0] m_data = '0;

    always @(posedge mdc) begin
        int k;
        k = edge_total - base;
        cap_mdo[edge_total % CAPN] = mdo;
        cap_oe[edge_total % CAPN]  = mdoe;
        if (k > 0 && (cyc - last_cyc) != 2 * HALF) per_bad++;
        last_cyc = cyc;
        edge_total++;
        k = k + 1;
        if (m_resp && k == 47) mdi = m_errbit;
        else if (m_resp && k >= 48 && k <= 63) mdi = m_data[63 - k];
        else mdi = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] frame_bits(input bit wr, input logic [4:0] p,
                                               input logic [4:0] r, input logic [15:0] d);
        return {2'b01, (wr ? 2'b01 : 2'b10), p, r, 2'b10, d};
    endfunction

    task automatic run(input bit wr, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d, input bit resp, input bit eb, input bit inject);
        int b, n, bad0;
        bit seen, ok, exp_err;
        logic [15:0] exp_data;
        logic [31:0] fr;
        m_resp = resp; m_errbit = eb; m_data = d;
        b = edge_total; base = b; bad0 = per_bad;
        @(negedge clk);
        start = 1'b1; write = wr; phy = p; regad = r; wdata = d;
        @(negedge clk);
        start = 1'b0; write = ~wr; phy = ~p; regad = ~r; wdata = ~d;
        chk(busy == 1'b1, "R11", "busy after start", busy, 1);
        if (inject) begin
            repeat (100) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R10", "still busy after ignored start", busy, 1);
        end
        n = 0; seen = 0;
        while (!seen && n < 4000) begin
            @(negedge clk);
            n++;
            if (done) seen = 1;
        end
        chk(seen, "R11", "done pulse seen", seen, 1);
        exp_err  = wr ? 1'b0 : (!resp || eb);
        exp_data = (wr || exp_err) ? 16'd0 : d;
        chk(err == exp_err, "R6", "error flag", err, exp_err);
        if (exp_err) chk(rdata == exp_data, "R6", "forced zero data", rdata, exp_data);
        else         chk(rdata == exp_data, "R7", "read data", rdata, exp_data);
        chk(busy == 1'b0, "R11", "busy low with done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done one cycle", done, 0);
        chk(mdc == 1'b0 && mdoe == 1'b1, "R1", "idle levels {mdc,oe}", {mdc, mdoe}, 2'b01);
        chk(edge_total - b == 64, wr ? "R4" : "R5", "rising edges per frame", edge_total - b, 64);
        fr = frame_bits(wr, p, r, d);
        ok = 1;
        for (int c = 0; c < 32; c++)
            if (cap_mdo[(b + c) % CAPN] !== 1'b1 || cap_oe[(b + c) % CAPN] !== 1'b1) ok = 0;
        chk(ok, "R2", "preamble bits", ok, 1);
        ok = 1;
        for (int c = 32; c < 46; c++)
            if (cap_mdo[(b + c) % CAPN] !== fr[31 - (c - 32)] || cap_oe[(b + c) % CAPN] !== 1'b1) ok = 0;
        chk(ok, "R3", "header bits", ok, 1);
        ok = 1;
        for (int c = 46; c < 64; c++) begin
            if (wr) begin
                if (cap_mdo[(b + c) % CAPN] !== fr[31 - (c - 32)] || cap_oe[(b + c) % CAPN] !== 1'b1) ok = 0;
            end else begin
                if (cap_oe[(b + c) % CAPN] !== 1'b0) ok = 0;
            end
        end
        chk(ok, wr ? "R4" : "R5", "frame tail", ok, 1);
        chk(per_bad == bad0, "R9", "rising edge spacing errors", per_bad - bad0, 0);
        if (inject) begin
            repeat (30) @(negedge clk);
            chk(busy == 1'b0 && edge_total - b == 64, "R10", "no second frame",
                edge_total - b, 64);
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        chk(mdc == 1'b0 && mdoe == 1'b1 && mdo == 1'b1, "R1", "reset line levels",
            {mdc, mdoe, mdo}, 3'b011);
        chk(busy == 1'b0 && done == 1'b0, "R1", "reset busy/done", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mdc == 1'b0 && busy == 1'b0, "R1", "idle after reset", {mdc, busy}, 0);

        run(1'b1, 5'd1,  5'd0,  16'hA5C3, 1'b1, 1'b0, 1'b0);
        run(1'b0, 5'd31, 5'd31, 16'hFFFF, 1'b1, 1'b0, 1'b0);
        run(1'b0, 5'd7,  5'd2,  16'h5AA5, 1'b0, 1'b0, 1'b0);
        run(1'b0, 5'd3,  5'd9,  16'h1234, 1'b1, 1'b1, 1'b0);
        run(1'b1, 5'd16, 5'd17, 16'h8001, 1'b1, 1'b0, 1'b1);
        run(1'b0, 5'd0,  5'd1,  16'h0001, 1'b1, 1'b0, 1'b1);

        for (int i = 0; i < NRAND; i++) begin
            run(1'($urandom % 2), 5'($urandom), 5'($urandom), 16'($urandom),
                ($urandom % 4) != 0, ($urandom % 5) == 0, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule